// File: doc/BRIEF.md
# Sixteen-bit multicycle RISC core

This block is a small processor core that executes a 16-bit user-level instruction set one instruction at a time. It holds eight 16-bit general registers and a program counter. Every instruction goes through fetch, decode, execute and writeback states. Loads and stores add one memory state between execute and writeback. The supported instructions cover immediate and register arithmetic and logic, shifts, set-on-compare, immediate loads, byte and word memory access, conditional branches, and jumps with a return link.

The core uses a single synchronous memory port for both instruction fetch and data access. All addresses are byte addresses. A request is valid for one cycle, and read data comes back on the following cycle. When the core decodes an undefined or privileged encoding it stops issuing requests and raises a sticky halt flag. The flag clears only on reset. A system integrator wires the port to a block RAM and watches the halt flag to detect end of program or a fault.

Top module: `mc16_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the core issues a read request (mem_req=1, mem_we=0) at byte address 0x0000 with halted=0.
- R2: Immediate ALU instructions take the register in bits 7:5 and a 5-bit immediate in bits 4:0, and write bits 10:8. The opcodes are 0 add (sign-extended immediate), 1 add, 2 and, 3 or, 4 xor and 5 nor. Opcodes 1 to 5 zero-extend the immediate.
- R3: Opcodes 24 and 25 read the registers in bits 7:5 (a) and 4:2 (b), write bits 10:8, and pick the function with bits 1:0. Opcode 24 gives a+b for function 0 and a-b for function 2. Opcode 25 gives and, or, xor and nor for functions 0 to 3.
- R4: Shifts use only the low four bits of the amount. Opcode 18 shifts left and opcode 19 shifts right logically, both by an immediate. Opcode 20 shifts right arithmetically, copying bit 15. Opcode 26 does the same three shifts for functions 0, 1 and 2, taking the amount from register b.
- R5: Opcode 27 writes 1 or 0 into the destination. Function 0 tests a==b, function 1 tests a!=b, function 2 tests a<b signed and function 3 tests a<b unsigned.
- R6: The destination is in bits 10:8 and an 8-bit immediate is in bits 7:0. Opcode 13 writes the sign-extended immediate and opcode 14 writes it zero-extended. Opcode 15 puts the immediate into the upper byte and keeps the destination's lower byte.
- R7: Loads write bits 10:8 from address (register in bits 7:5) plus a sign-extended 5-bit immediate. Opcode 10 loads a sign-extended byte, 11 a zero-extended byte and 12 a word. An even address selects the low byte of the word.
- R8: Stores use the base register in bits 10:8, the data register in bits 7:5 and a signed 5-bit offset. Opcode 17 writes a word. Opcode 16 writes only the addressed byte lane: byte enable 01 for an even address and 10 for an odd one.
- R9: Opcodes 6 and 7 jump to PC+2 plus twice the signed 11-bit field in bits 10:0. Opcode 7 also writes PC+2 into r7.
- R10: Opcodes 8 and 9 jump to the register in bits 10:8 plus the sign-extended bits 7:0. Opcode 9 also writes PC+2 into r7, after the target has been taken from the old register value.
- R11: Opcode 22 branches to PC+2 plus twice the signed bits 7:0 when the register in bits 10:8 is zero. Opcode 23 branches when it is nonzero. Otherwise execution falls through to PC+2.
- R12: The following encodings set halted and retire nothing further: opcode 21, opcode 24 with function 1 or 3, opcode 26 with function 3, and opcodes 28 to 31. Once halted, the core never raises mem_req again until reset.
- R13: Each memory request lasts exactly one cycle, and no request follows in the next cycle. A write is always a request with a nonzero byte enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory request strobe, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_be | output | 2 | Byte lane enables for writes (bit 0 = even byte) |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data; a byte store repeats the byte in both lanes |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| halted | output | 1 | Sticky flag for an undefined instruction |

## Verification
The bound checker checks the memory protocol on every cycle: single-cycle requests, writes that always carry a request and a nonzero lane mask, and byte stores that drive one lane. It also checks that the halt flag is sticky, that no request appears while halted, and that the first fetch after reset goes to the reset address. Instruction results, the extension rules, branch direction, link values and load lane selection are only visible through the bench's programs. Each program stores its results to memory, where the bench compares them with values its own reference functions compute, both for random operands and for corner values such as 0x8000 and shift amounts above 15.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int XW  = 16;
  localparam int RAW = 3;
  localparam int NREG = 2 ** RAW;

  typedef enum logic [3:0] {
    A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_NOR,
    A_SLL, A_SRL, A_SRA, A_SEQ, A_SNE, A_SLT, A_SLTU, A_PASSB
  } alu_op_e;

  typedef enum logic [2:0] {FL_SEQ, FL_REL, FL_REG, FL_BZ, FL_BNZ} flow_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DEC, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } state_e;

  typedef struct packed {
    alu_op_e       op;
    logic          a_hi;
    logic          b_imm;
    logic          lui;
    logic [XW-1:0] imm;
    flow_e         flow;
    logic          wr;
    logic          link;
    logic          ld;
    logic          st;
    logic          byte_op;
    logic          ld_signed;
    logic          illegal;
  } ctrl_t;
endpackage

// File: rtl/mc16_decode.sv
module mc16_decode
  import mc16_pkg::*;
(
  input  logic [XW-1:0] ir,
  output ctrl_t         ctl
);
  logic [4:0]    opc;
  logic [1:0]    fn;
  logic [XW-1:0] s5, u5, s8, u8;

  assign opc = ir[15:11];
  assign fn  = ir[1:0];
  assign s5  = {{(XW-5){ir[4]}}, ir[4:0]};
  assign u5  = {{(XW-5){1'b0}}, ir[4:0]};
  assign s8  = {{(XW-8){ir[7]}}, ir[7:0]};
  assign u8  = {{(XW-8){1'b0}}, ir[7:0]};

  always_comb begin
    ctl      = '0;
    ctl.op   = A_ADD;
    ctl.flow = FL_SEQ;
    ctl.imm  = s5;
    case (opc)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd18, 5'd19, 5'd20: begin
        ctl.wr    = 1'b1;
        ctl.b_imm = 1'b1;
        ctl.imm   = (opc == 5'd0) ? s5 : u5;
        case (opc)
          5'd2:    ctl.op = A_AND;
          5'd3:    ctl.op = A_OR;
          5'd4:    ctl.op = A_XOR;
          5'd5:    ctl.op = A_NOR;
          5'd18:   ctl.op = A_SLL;
          5'd19:   ctl.op = A_SRL;
          5'd20:   ctl.op = A_SRA;
          default: ctl.op = A_ADD;
        endcase
      end
      5'd6:  ctl.flow = FL_REL;
      5'd7:  begin ctl.flow = FL_REL; ctl.wr = 1'b1; ctl.link = 1'b1; end
      5'd8:  begin ctl.flow = FL_REG; ctl.imm = s8; end
      5'd9:  begin ctl.flow = FL_REG; ctl.imm = s8; ctl.wr = 1'b1; ctl.link = 1'b1; end
      5'd10, 5'd11, 5'd12: begin
        ctl.wr        = 1'b1;
        ctl.ld        = 1'b1;
        ctl.b_imm     = 1'b1;
        ctl.byte_op   = (opc != 5'd12);
        ctl.ld_signed = (opc == 5'd10);
      end
      5'd13: begin ctl.wr = 1'b1; ctl.op = A_PASSB; ctl.b_imm = 1'b1; ctl.imm = s8; end
      5'd14: begin ctl.wr = 1'b1; ctl.op = A_PASSB; ctl.b_imm = 1'b1; ctl.imm = u8; end
      5'd15: begin ctl.wr = 1'b1; ctl.op = A_PASSB; ctl.lui = 1'b1; end
      5'd16, 5'd17: begin
        ctl.st      = 1'b1;
        ctl.a_hi    = 1'b1;
        ctl.b_imm   = 1'b1;
        ctl.byte_op = (opc == 5'd16);
      end
      5'd22: ctl.flow = FL_BZ;
      5'd23: ctl.flow = FL_BNZ;
      5'd24: begin
        ctl.wr      = 1'b1;
        ctl.op      = fn[1] ? A_SUB : A_ADD;
        ctl.illegal = fn[0];
      end
      5'd25: begin
        ctl.wr = 1'b1;
        case (fn)
          2'd0:    ctl.op = A_AND;
          2'd1:    ctl.op = A_OR;
          2'd2:    ctl.op = A_XOR;
          default: ctl.op = A_NOR;
        endcase
      end
      5'd26: begin
        ctl.wr = 1'b1;
        case (fn)
          2'd0:    ctl.op = A_SLL;
          2'd1:    ctl.op = A_SRL;
          2'd2:    ctl.op = A_SRA;
          default: ctl.illegal = 1'b1;
        endcase
      end
      5'd27: begin
        ctl.wr = 1'b1;
        case (fn)
          2'd0:    ctl.op = A_SEQ;
          2'd1:    ctl.op = A_SNE;
          2'd2:    ctl.op = A_SLT;
          default: ctl.op = A_SLTU;
        endcase
      end
      default: ctl.illegal = 1'b1;
    endcase
    if (ctl.illegal) ctl.wr = 1'b0;
  end
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
(
  input  alu_op_e       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y
);
  logic [3:0] sh;
  assign sh = b[3:0];

  always_comb begin
    case (op)
      A_ADD:   y = a + b;
      A_SUB:   y = a - b;
      A_AND:   y = a & b;
      A_OR:    y = a | b;
      A_XOR:   y = a ^ b;
      A_NOR:   y = ~(a | b);
      A_SLL:   y = a << sh;
      A_SRL:   y = a >> sh;
      A_SRA:   y = XW'($signed(a) >>> sh);
      A_SEQ:   y = XW'(a == b);
      A_SNE:   y = XW'(a != b);
      A_SLT:   y = XW'($signed(a) < $signed(b));
      A_SLTU:  y = XW'(a < b);
      default: y = b;
    endcase
  end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DW = 16,
  parameter int NR = 8,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_x,
  input  logic [AW-1:0] ra_y,
  input  logic [AW-1:0] ra_z,
  output logic [DW-1:0] rd_x,
  output logic [DW-1:0] rd_y,
  output logic [DW-1:0] rd_z
);
  logic [DW-1:0] regs [NR];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rd_x = regs[ra_x];
  assign rd_y = regs[ra_y];
  assign rd_z = regs[ra_z];
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_be,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        halted
);
  localparam logic [RAW-1:0] LINK_REG = RAW'(NREG - 1);

  state_e        state;
  logic [XW-1:0] pc, ir, res_q, npc, nxt_pc;
  logic [XW-1:0] rx, ry, rz, alu_a, alu_b, alu_y, pc_inc, ld_val, wb_data;
  logic [7:0]    ld_byte;
  logic [RAW-1:0] wb_addr;
  logic          wb_en;
  ctrl_t         ctl;

  mc16_decode u_dec (.ir(ir), .ctl(ctl));

  mc16_regfile #(.DW(XW), .NR(NREG)) u_rf (
    .clk(clk), .we(wb_en), .waddr(wb_addr), .wdata(wb_data),
    .ra_x(ir[10:8]), .ra_y(ir[7:5]), .ra_z(ir[4:2]),
    .rd_x(rx), .rd_y(ry), .rd_z(rz)
  );

  assign alu_a = ctl.a_hi ? rx : ry;
  assign alu_b = ctl.lui ? {ir[7:0], rx[7:0]} : (ctl.b_imm ? ctl.imm : rz);

  mc16_alu u_alu (.op(ctl.op), .a(alu_a), .b(alu_b), .y(alu_y));

  assign pc_inc = pc + XW'(2);

  always_comb begin
    case (ctl.flow)
      FL_REL:  nxt_pc = pc_inc + {{(XW-12){ir[10]}}, ir[10:0], 1'b0};
      FL_REG:  nxt_pc = rx + ctl.imm;
      FL_BZ:   nxt_pc = (rx == '0) ? pc_inc + {{(XW-9){ir[7]}}, ir[7:0], 1'b0} : pc_inc;
      FL_BNZ:  nxt_pc = (rx != '0) ? pc_inc + {{(XW-9){ir[7]}}, ir[7:0], 1'b0} : pc_inc;
      default: nxt_pc = pc_inc;
    endcase
  end

  assign ld_byte = res_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];
  assign ld_val  = !ctl.byte_op ? mem_rdata :
                   {{(XW-8){ctl.ld_signed & ld_byte[7]}}, ld_byte};
  assign wb_en   = (state == ST_WB) && ctl.wr;
  assign wb_addr = ctl.link ? LINK_REG : ir[10:8];
  assign wb_data = ctl.ld ? ld_val : res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      pc        <= RESET_PC;
      ir        <= '0;
      res_q     <= '0;
      npc       <= '0;
      mem_req   <= 1'b1;
      mem_we    <= 1'b0;
      mem_be    <= 2'b11;
      mem_addr  <= RESET_PC;
      mem_wdata <= '0;
      halted    <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: begin
          mem_req <= 1'b0;
          state   <= ST_DEC;
        end
        ST_DEC: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (ctl.illegal) begin
            halted <= 1'b1;
            state  <= ST_HALT;
          end else begin
            res_q <= ctl.link ? pc_inc : alu_y;
            npc   <= nxt_pc;
            if (ctl.ld || ctl.st) begin
              mem_req   <= 1'b1;
              mem_we    <= ctl.st;
              mem_addr  <= alu_y;
              mem_be    <= !ctl.byte_op ? 2'b11 : (alu_y[0] ? 2'b10 : 2'b01);
              mem_wdata <= ctl.byte_op ? {ry[7:0], ry[7:0]} : ry;
              state     <= ST_MEM;
            end else begin
              state <= ST_WB;
            end
          end
        end
        ST_MEM: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state   <= ST_WB;
        end
        ST_WB: begin
          pc       <= npc;
          mem_req  <= 1'b1;
          mem_addr <= npc;
          mem_be   <= 2'b11;
          state    <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/mc16_chk.sv
module mc16_chk #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [1:0]  mem_be,
  input logic [15:0] mem_addr,
  input logic        halted
);
  // R1
  first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_req && !mem_we && mem_addr == RESET_PC && !halted));
  // R13
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R13
  write_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_req && mem_be != 2'b00));
  // R8
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be != 2'b11) |-> $onehot(mem_be));
  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_req);
endmodule

bind mc16_core mc16_chk #(.RESET_PC(RESET_PC)) u_chk (.*);

// File: tb/tb_mc16_core.sv
module tb_mc16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we, halted;
  logic [1:0]  mem_be;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem [512];
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] pa;

  localparam logic [15:0] HALT = {5'd21, 11'd0};

  always #2 clk = ~clk;

  mc16_core dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[9:1]][7:0]  = mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[9:1]][15:8] = mem_wdata[15:8];
      end else begin
        mem_rdata <= mem[mem_addr[9:1]];
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R13 watchdog expired: got %0d cycles exp fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] encI(int op, int a, int b, logic [4:0] imm);
    return {5'(op), 3'(a), 3'(b), imm};
  endfunction
  function automatic logic [15:0] encII(int op, int r, logic [7:0] imm);
    return {5'(op), 3'(r), imm};
  endfunction
  function automatic logic [15:0] encJ(int op, logic [10:0] imm);
    return {5'(op), imm};
  endfunction
  function automatic logic [15:0] encR(int op, int d, int s1, int s2, int fn);
    return {5'(op), 3'(d), 3'(s1), 3'(s2), 2'(fn)};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = '0;
    pa = '0;
  endtask
  task automatic emit(input logic [15:0] w);
    mem[pa[9:1]] = w;
    pa = pa + 16'd2;
  endtask
  task automatic load_reg(input int r, input logic [15:0] v);
    emit(encII(14, r, v[7:0]));
    emit(encII(15, r, v[15:8]));
  endtask
  function automatic logic [15:0] rdw(input logic [15:0] a);
    return mem[a[9:1]];
  endfunction

  task automatic run_prog(input string tag);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      if (halted) break;
    end
    chk({tag, " R12 halt reached"}, {15'b0, halted}, 16'h0001);
  endtask

  function automatic logic [15:0] model(input logic [4:0] op, input logic [1:0] fn,
                                        input logic [15:0] a, input logic [15:0] b,
                                        input logic [4:0] imm);
    logic [15:0] s5 = {{11{imm[4]}}, imm};
    logic [15:0] u5 = {11'b0, imm};
    case (op)
      5'd0:  return a + s5;
      5'd1:  return a + u5;
      5'd2:  return a & u5;
      5'd3:  return a | u5;
      5'd4:  return a ^ u5;
      5'd5:  return ~(a | u5);
      5'd18: return a << imm[3:0];
      5'd19: return a >> imm[3:0];
      5'd20: return 16'($signed(a) >>> imm[3:0]);
      5'd24: return fn[1] ? a - b : a + b;
      5'd25: case (fn) 2'd0: return a & b; 2'd1: return a | b;
                       2'd2: return a ^ b; default: return ~(a | b); endcase
      5'd26: case (fn) 2'd0: return a << b[3:0]; 2'd1: return a >> b[3:0];
                       default: return 16'($signed(a) >>> b[3:0]); endcase
      default: case (fn) 2'd0: return {15'b0, a == b}; 2'd1: return {15'b0, a != b};
                         2'd2: return {15'b0, $signed(a) < $signed(b)};
                         default: return {15'b0, a < b}; endcase
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5'd5) return "R2";
    if (op == 5'd24 || op == 5'd25) return "R3";
    if (op == 5'd27) return "R5";
    return "R4";
  endfunction

  task automatic do_alu(input logic [4:0] op, input logic [1:0] fn, input logic [15:0] a,
                        input logic [15:0] b, input logic [4:0] imm, output logic [15:0] got);
    clear_mem();
    emit(encII(14, 5, 8'h80));
    load_reg(1, a);
    load_reg(2, b);
    if (op >= 5'd24) emit(encR(op, 3, 1, 2, fn));
    else emit(encI(op, 3, 1, imm));
    emit(encI(17, 5, 3, 5'd0));
    emit(HALT);
    run_prog(req_of(op));
    got = rdw(16'h0080);
  endtask

  function automatic logic [6:0] pick(input int i);
    int j;
    if (i < 6) return {5'(i), 2'd0};
    if (i < 9) return {5'(i + 12), 2'd0};
    j = i - 9;
    if (j < 2) return {5'd24, 2'(j * 2)};
    if (j < 6) return {5'd25, 2'(j - 2)};
    if (j < 9) return {5'd26, 2'(j - 6)};
    return {5'd27, 2'(j - 9)};
  endfunction

  function automatic logic [15:0] rnd_val();
    logic [15:0] corner [4] = '{16'h8000, 16'hFFFF, 16'h0000, 16'h7FFF};
    if ($urandom_range(0, 3) == 0) return corner[$urandom_range(0, 3)];
    return 16'($urandom);
  endfunction

  function automatic logic [15:0] bad_code(input int k);
    case (k)
      0: return HALT;
      1: return encR(24, 1, 1, 1, 1);
      2: return encR(24, 1, 1, 1, 3);
      3: return encR(26, 1, 1, 1, 3);
      4: return encR(28, 0, 0, 0, 0);
      5: return encR(29, 0, 0, 0, 0);
      6: return encR(30, 0, 0, 0, 1);
      default: return encR(31, 0, 0, 0, 0);
    endcase
  endfunction

  initial begin
    logic [15:0] got, a, b;
    logic [6:0]  sel;
    logic [4:0]  imm;
    void'($urandom(32'd1234));
    clear_mem();

    // R1 reset state and R13 single-cycle request
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 mem_req in reset", {15'b0, mem_req}, 16'h0001);
    chk("R1 mem_addr in reset", mem_addr, 16'h0000);
    chk("R1 mem_we in reset", {15'b0, mem_we}, 16'h0000);
    chk("R1 halted in reset", {15'b0, halted}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 request lasts one cycle", {15'b0, mem_req}, 16'h0000);

    // R4 directed shift corners
    do_alu(5'd20, 2'd0, 16'h8001, 16'h0, 5'h11, got);
    chk("R4 srai amount 17 uses low four bits", got, 16'hC000);
    do_alu(5'd26, 2'd0, 16'h0001, 16'h0014, 5'h0, got);
    chk("R4 sll amount 0x14", got, 16'h0010);
    // R2 directed sign extension
    do_alu(5'd0, 2'd0, 16'h0010, 16'h0, 5'h1F, got);
    chk("R2 addi negative immediate", got, 16'h000F);
    do_alu(5'd1, 2'd0, 16'h0010, 16'h0, 5'h1F, got);
    chk("R2 addiu zero-extended", got, 16'h002F);
    // R5 signed versus unsigned
    do_alu(5'd27, 2'd2, 16'h8000, 16'h0001, 5'h0, got);
    chk("R5 slt signed", got, 16'h0001);
    do_alu(5'd27, 2'd3, 16'h8000, 16'h0001, 5'h0, got);
    chk("R5 sltu unsigned", got, 16'h0000);

    // R2 R3 R4 R5 random operations against the reference functions
    for (int it = 0; it < 60; it++) begin
      sel = pick($urandom_range(0, 21));
      a = rnd_val();
      b = rnd_val();
      imm = 5'($urandom);
      do_alu(sel[6:2], sel[1:0], a, b, imm, got);
      chk($sformatf("%s op %0d fn %0d a %h b %h imm %h", req_of(sel[6:2]), sel[6:2], sel[1:0], a, b, imm),
          got, model(sel[6:2], sel[1:0], a, b, imm));
    end

    // R6 immediate loads
    clear_mem();
    emit(encII(14, 5, 8'h80));
    emit(encII(13, 1, 8'h80));
    emit(encII(14, 2, 8'h80));
    emit(encII(14, 3, 8'h34));
    emit(encII(15, 3, 8'h12));
    emit(encII(13, 4, 8'h7F));
    emit(encI(17, 5, 1, 5'd0));
    emit(encI(17, 5, 2, 5'd2));
    emit(encI(17, 5, 3, 5'd4));
    emit(encI(17, 5, 4, 5'd6));
    emit(HALT);
    run_prog("R6");
    chk("R6 li sign-extends", rdw(16'h0080), 16'hFF80);
    chk("R6 liu zero-extends", rdw(16'h0082), 16'h0080);
    chk("R6 lui keeps low byte", rdw(16'h0084), 16'h1234);
    chk("R6 li positive", rdw(16'h0086), 16'h007F);

    // R7 R8 loads and stores
    clear_mem();
    mem[16'h0080 >> 1] = 16'h80F1;
    mem[16'h0088 >> 1] = 16'hAAAA;
    mem[16'h008A >> 1] = 16'h3333;
    mem[16'h008E >> 1] = 16'h5A5A;
    emit(encII(14, 5, 8'h80));
    emit(encII(14, 6, 8'h90));
    emit(encI(10, 1, 5, 5'd1));
    emit(encI(11, 2, 5, 5'd1));
    emit(encI(12, 3, 5, 5'd0));
    emit(encI(10, 4, 5, 5'd0));
    emit(encI(12, 0, 6, 5'h1E));
    emit(encI(16, 5, 1, 5'd9));
    emit(encI(16, 6, 2, 5'h1A));
    emit(encI(17, 6, 1, 5'd0));
    emit(encI(17, 6, 2, 5'd2));
    emit(encI(17, 6, 3, 5'd4));
    emit(encI(17, 6, 4, 5'd6));
    emit(encI(17, 6, 0, 5'd8));
    emit(HALT);
    run_prog("R7");
    chk("R7 lb odd byte sign-extended", rdw(16'h0090), 16'hFF80);
    chk("R7 lbu odd byte", rdw(16'h0092), 16'h0080);
    chk("R7 lw word", rdw(16'h0094), 16'h80F1);
    chk("R7 lb even byte", rdw(16'h0096), 16'hFFF1);
    chk("R7 lw negative offset", rdw(16'h0098), 16'h5A5A);
    chk("R8 sb odd lane only", rdw(16'h0088), 16'h80AA);
    chk("R8 sb even lane negative offset", rdw(16'h008A), 16'h3380);

    // R11 branches taken and not taken
    clear_mem();
    emit(encII(14, 5, 8'h80));
    emit(encII(14, 1, 8'h00));
    emit(encII(14, 2, 8'h01));
    emit(encII(14, 3, 8'h77));
    emit(encII(22, 1, 8'd1));
    emit(encII(14, 3, 8'h11));
    emit(encII(23, 1, 8'd1));
    emit(encII(14, 4, 8'h22));
    emit(encII(23, 2, 8'd1));
    emit(encII(14, 4, 8'h33));
    emit(encII(22, 2, 8'd1));
    emit(encI(17, 5, 3, 5'd0));
    emit(encI(17, 5, 4, 5'd2));
    emit(HALT);
    run_prog("R11");
    chk("R11 bz taken skips", rdw(16'h0080), 16'h0077);
    chk("R11 bnz taken and bz fall-through", rdw(16'h0082), 16'h0022);

    // R11 backward branch loop
    clear_mem();
    emit(encII(14, 5, 8'h80));
    emit(encII(14, 1, 8'd3));
    emit(encII(14, 2, 8'd0));
    emit(encI(0, 2, 2, 5'd2));
    emit(encI(0, 1, 1, 5'h1F));
    emit(encII(23, 1, 8'hFD));
    emit(encI(17, 5, 2, 5'd0));
    emit(HALT);
    run_prog("R11");
    chk("R11 backward loop count", rdw(16'h0080), 16'h0006);

    // R9 R10 jumps and links
    clear_mem();
    emit(encII(14, 5, 8'h80));
    emit(encII(14, 1, 8'h55));
    emit(encJ(6, 11'd1));
    emit(encII(14, 1, 8'h66));
    emit(encJ(7, 11'd4));
    emit(encI(17, 5, 4, 5'd2));
    emit(encI(17, 5, 7, 5'd4));
    emit(encI(17, 5, 1, 5'd6));
    emit(HALT);
    emit(encI(17, 5, 7, 5'd0));
    emit(encII(14, 4, 8'h99));
    emit(encII(9, 7, 8'd0));
    run_prog("R9");
    chk("R9 jal link value", rdw(16'h0080), 16'h000A);
    chk("R10 jalr returns", rdw(16'h0082), 16'h0099);
    chk("R10 jalr link value", rdw(16'h0084), 16'h0018);
    chk("R9 j skips", rdw(16'h0086), 16'h0055);

    // R10 R9 negative offsets
    clear_mem();
    emit(encII(14, 5, 8'h80));
    emit(encII(14, 1, 8'h10));
    emit(encII(8, 1, 8'hFE));
    for (int i = 0; i < 4; i++) emit(HALT);
    emit(encII(14, 2, 8'h44));
    emit(encI(17, 5, 2, 5'd0));
    emit(encJ(6, 11'h7F9));
    run_prog("R10");
    chk("R10 jr negative offset and R9 backward j", rdw(16'h0080), 16'h0044);

    // R12 every undefined encoding halts without retiring more
    for (int k = 0; k < 8; k++) begin
      clear_mem();
      mem[16'h0080 >> 1] = 16'hDEAD;
      emit(encII(14, 5, 8'h80));
      emit(encII(14, 1, 8'h05));
      emit(bad_code(k));
      emit(encI(17, 5, 1, 5'd0));
      emit(HALT);
      run_prog($sformatf("R12 code %h", bad_code(k)));
      repeat (4) @(negedge clk);
      chk($sformatf("R12 no request after halt, code %h", bad_code(k)), {15'b0, mem_req}, 16'h0000);
      chk($sformatf("R12 store after illegal not done, code %h", bad_code(k)), rdw(16'h0080), 16'hDEAD);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule